// File: doc/BRIEF.md
# Dual-Issue Pairing Hazard Checker

This block sits at the issue stage of a two-wide, in-order integer and floating-point pipeline. Each cycle it receives two decoded instruction class codes, an older and a younger candidate, with a valid bit for each. It decides how many of them may leave together: none, the older alone, or both. It models the structural resources of a single cycle: two issue slots, integer pipe A (add/sub/address generation or shifter), integer pipe B (add/sub, branch or multiply/divide), one cache port, and one floating-point front end shared by the adder, the multiplier and the divide/square-root unit.

Two hazards carry over from one cycle to the next, and the block holds them in its own registers. The first is a store keeping the cache port for extra cycles. The second is the empty issue cycle that follows a taken branch, jump or call. Iterative units that stay occupied for many cycles (integer multiply/divide, floating-point multiply and floating-point divide/square root) report their occupancy through busy inputs. The issue stage advances its instruction queue by `issue_count` and uses `stall` to learn that a valid candidate was held back.

Class codes on `old_cls` and `yng_cls`: 0 integer add/sub (either pipe), 1 shift, 2 integer load, 3 integer store, 4 FP load, 5 FP store, 6 FP-to/from-integer move, 7 integer multiply/divide, 8 branch/jump/call, 9 FP add, 10 FP multiply, 11 FP divide/sqrt, 12 to 15 single-dispatch (conditional move, unknown, multi, atomic, sync loop).

Top module: `pair_issue_gate`

## Requirements
- R1: `issue_count` is always 0, 1 or 2, and issue is in order. When `old_valid` is 0, `issue_count` is 0. The younger candidate issues only when the older one also issues.
- R2: Pipe A takes at most one instruction per cycle. Shift (1), loads and stores (2 to 5) and FP moves (6) each need pipe A, so no two of them issue together.
- R3: Pipe B takes at most one of multiply/divide (7) and branch (8) per cycle. Integer add/sub (0) can use either pipe, so it pairs with another add/sub or with any one of codes 1 to 8.
- R4: Only one of FP add (9), FP multiply (10) and FP divide/sqrt (11) issues per cycle. Any one of them pairs with an integer-side class.
- R5: After an integer store (3) issues, no load or store (2 to 5) issues in the next cycle. After an FP store (5) issues, none issues in the next two cycles.
- R6: After a branch (8) issues in either slot, `issue_count` is 0 in the next cycle.
- R7: Single-dispatch classes (12 to 15) never pair. They issue alone as the older candidate, and as the younger candidate they wait.
- R8: When `imd_busy`, `fmul_busy` or `fdsq_busy` is high, no instruction of class 7, 10 or 11 respectively issues in that cycle.
- R9: `stall` is 1 exactly when the number of valid candidates exceeds `issue_count`.
- R10: Reset clears the store hold and the branch bubble, so a load issues in the first cycle after reset even if a store or a branch issued just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| old_valid | input | 1 | Older candidate present |
| old_cls | input | 4 | Older candidate class code |
| yng_valid | input | 1 | Younger candidate present |
| yng_cls | input | 4 | Younger candidate class code |
| imd_busy | input | 1 | Integer multiply/divide iterator occupied |
| fmul_busy | input | 1 | FP multiply iterator occupied |
| fdsq_busy | input | 1 | FP divide/sqrt iterator occupied |
| issue_count | output | 2 | Number of candidates issued this cycle |
| stall | output | 1 | A valid candidate was held back |

## Verification
The only internal state is the cache-hold counter and the bubble flag. If either is wrong, the error shows up at `issue_count` in the first cycle that offers a memory operation or any instruction after the event that should have set or cleared it. A hold that lasts too long or too short makes a load issue one cycle early or late. A bubble that sticks keeps `issue_count` at zero. The bench places loads directly after integer stores, FP stores, branches and a mid-run reset, so an off-by-one counter becomes visible within three cycles. A behavioural model runs alongside and compares every cycle of a long mixed stream.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CL_IALU    = 4'd0;
  localparam logic [CLS_W-1:0] CL_SHIFT   = 4'd1;
  localparam logic [CLS_W-1:0] CL_LOAD    = 4'd2;
  localparam logic [CLS_W-1:0] CL_STORE   = 4'd3;
  localparam logic [CLS_W-1:0] CL_FLOAD   = 4'd4;
  localparam logic [CLS_W-1:0] CL_FSTORE  = 4'd5;
  localparam logic [CLS_W-1:0] CL_FXFER   = 4'd6;
  localparam logic [CLS_W-1:0] CL_IMULDIV = 4'd7;
  localparam logic [CLS_W-1:0] CL_BRANCH  = 4'd8;
  localparam logic [CLS_W-1:0] CL_FADD    = 4'd9;
  localparam logic [CLS_W-1:0] CL_FMUL    = 4'd10;
  localparam logic [CLS_W-1:0] CL_FDSQ    = 4'd11;

  // Resource demand of one candidate for the current cycle.
  typedef struct packed {
    logic pipe_a;    // needs pipe A exclusively
    logic pipe_b;    // needs pipe B exclusively
    logic fp_unit;   // needs the shared FP front end
    logic cache;     // needs the cache port
    logic solo;      // takes both issue slots
    logic branch;    // causes an issue bubble next cycle
    logic int_store; // holds cache port (short)
    logic fp_store;  // holds cache port (long)
    logic use_imd;   // blocked by integer iterator
    logic use_fmul;  // blocked by FP multiply iterator
    logic use_fdsq;  // blocked by FP divide/sqrt iterator
  } pig_need_t;

endpackage

// File: rtl/pair_issue_decode.sv
module pair_issue_decode
  import pair_issue_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output pig_need_t        need
);

  always_comb begin
    need = '0;
    unique case (cls)
      CL_IALU:    ; // flexible: either integer pipe
      CL_SHIFT:   need.pipe_a = 1'b1;
      CL_LOAD,
      CL_FLOAD: begin
        need.pipe_a = 1'b1;
        need.cache  = 1'b1;
      end
      CL_STORE: begin
        need.pipe_a    = 1'b1;
        need.cache     = 1'b1;
        need.int_store = 1'b1;
      end
      CL_FSTORE: begin
        need.pipe_a   = 1'b1;
        need.cache    = 1'b1;
        need.fp_store = 1'b1;
      end
      CL_FXFER:   need.pipe_a = 1'b1;
      CL_IMULDIV: begin
        need.pipe_b  = 1'b1;
        need.use_imd = 1'b1;
      end
      CL_BRANCH: begin
        need.pipe_b = 1'b1;
        need.branch = 1'b1;
      end
      CL_FADD:    need.fp_unit = 1'b1;
      CL_FMUL: begin
        need.fp_unit  = 1'b1;
        need.use_fmul = 1'b1;
      end
      CL_FDSQ: begin
        need.fp_unit  = 1'b1;
        need.use_fdsq = 1'b1;
      end
      default:    need.solo = 1'b1;
    endcase
  end

endmodule

// File: rtl/pair_issue_arbiter.sv
module pair_issue_arbiter
  import pair_issue_pkg::*;
(
  input  logic            old_valid,
  input  logic            yng_valid,
  input  pig_need_t [1:0] need,
  input  logic            hold_busy,
  input  logic            bubble,
  input  logic            imd_busy,
  input  logic            fmul_busy,
  input  logic            fdsq_busy,
  output logic [1:0]      issued,
  output logic [1:0]      issue_count,
  output logic            stall
);

  logic [1:0] avail;     // per slot: its own resources are free
  logic       old_ok;
  logic       share_ok;  // no intra-cycle conflict between the two
  logic       pair_ok;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      avail[s] = !(need[s].cache    && hold_busy) &&
                 !(need[s].use_imd  && imd_busy)  &&
                 !(need[s].use_fmul && fmul_busy) &&
                 !(need[s].use_fdsq && fdsq_busy);
    end

    share_ok = !need[0].solo && !need[1].solo &&
               !(need[0].pipe_a  && need[1].pipe_a) &&
               !(need[0].pipe_b  && need[1].pipe_b) &&
               !(need[0].fp_unit && need[1].fp_unit);

    old_ok  = old_valid && !bubble && avail[0];
    pair_ok = old_ok && yng_valid && avail[1] && share_ok;

    issued      = {pair_ok, old_ok};
    issue_count = pair_ok ? 2'd2 : (old_ok ? 2'd1 : 2'd0);
    stall       = (old_valid && !old_ok) || (yng_valid && !pair_ok);
  end

endmodule

// File: rtl/pair_issue_carry.sv
module pair_issue_carry
  import pair_issue_pkg::*;
#(
  parameter int ST_HOLD  = 1,
  parameter int FST_HOLD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pig_need_t [1:0] need,
  input  logic [1:0]      issued,
  output logic            hold_busy,
  output logic            bubble
);

  localparam int HOLD_MAX = (FST_HOLD > ST_HOLD) ? FST_HOLD : ST_HOLD;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);

  logic [CNT_W-1:0] hold_q, hold_d;
  logic             hold_en;
  logic             bub_q, bub_d;
  logic             st_iss, fst_iss, br_iss;

  // next-state
  always_comb begin
    st_iss  = 1'b0;
    fst_iss = 1'b0;
    br_iss  = 1'b0;
    for (int s = 0; s < 2; s++) begin
      st_iss  = st_iss  | (issued[s] & need[s].int_store);
      fst_iss = fst_iss | (issued[s] & need[s].fp_store);
      br_iss  = br_iss  | (issued[s] & need[s].branch);
    end

    hold_en = st_iss || fst_iss || (hold_q != '0);
    if (fst_iss)
      hold_d = CNT_W'(FST_HOLD);
    else if (st_iss)
      hold_d = CNT_W'(ST_HOLD);
    else if (hold_q != '0)
      hold_d = hold_q - 1'b1;
    else
      hold_d = hold_q;

    bub_d = br_iss;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bub_q <= 1'b0;
    end else begin
      bub_q <= bub_d;
    end
  end

  assign hold_busy = (hold_q != '0);
  assign bubble    = bub_q;

endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import pair_issue_pkg::*;
#(
  parameter int ST_HOLD  = 1,
  parameter int FST_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             old_valid,
  input  logic [CLS_W-1:0] old_cls,
  input  logic             yng_valid,
  input  logic [CLS_W-1:0] yng_cls,
  input  logic             imd_busy,
  input  logic             fmul_busy,
  input  logic             fdsq_busy,
  output logic [1:0]       issue_count,
  output logic             stall
);

  logic [1:0][CLS_W-1:0] slot_cls;
  pig_need_t [1:0]       need;
  logic [1:0]            issued;
  logic                  hold_busy;
  logic                  bubble;

  assign slot_cls[0] = old_cls;
  assign slot_cls[1] = yng_cls;

  for (genvar s = 0; s < 2; s++) begin : g_dec
    pair_issue_decode u_dec (
      .cls  (slot_cls[s]),
      .need (need[s])
    );
  end

  pair_issue_arbiter u_arb (
    .old_valid   (old_valid),
    .yng_valid   (yng_valid),
    .need        (need),
    .hold_busy   (hold_busy),
    .bubble      (bubble),
    .imd_busy    (imd_busy),
    .fmul_busy   (fmul_busy),
    .fdsq_busy   (fdsq_busy),
    .issued      (issued),
    .issue_count (issue_count),
    .stall       (stall)
  );

  pair_issue_carry #(
    .ST_HOLD  (ST_HOLD),
    .FST_HOLD (FST_HOLD)
  ) u_carry (
    .clk       (clk),
    .rst_n     (rst_n),
    .need      (need),
    .issued    (issued),
    .hold_busy (hold_busy),
    .bubble    (bubble)
  );

endmodule

// File: rtl/pair_issue_gate_chk.sv
module pair_issue_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       old_valid,
  input logic [3:0] old_cls,
  input logic       yng_valid,
  input logic [3:0] yng_cls,
  input logic       imd_busy,
  input logic       fmul_busy,
  input logic       fdsq_busy,
  input logic [1:0] issue_count,
  input logic       stall
);

  logic o_iss, y_iss;
  logic o_a, y_a, o_b, y_b, o_f, y_f, o_m, y_m;
  logic mem_iss, st_iss, fst_iss, br_iss;

  always_comb begin
    o_iss   = (issue_count != 2'd0);
    y_iss   = (issue_count == 2'd2);
    o_a     = (old_cls >= 4'd1) && (old_cls <= 4'd6);
    y_a     = (yng_cls >= 4'd1) && (yng_cls <= 4'd6);
    o_b     = (old_cls == 4'd7) || (old_cls == 4'd8);
    y_b     = (yng_cls == 4'd7) || (yng_cls == 4'd8);
    o_f     = (old_cls >= 4'd9) && (old_cls <= 4'd11);
    y_f     = (yng_cls >= 4'd9) && (yng_cls <= 4'd11);
    o_m     = (old_cls >= 4'd2) && (old_cls <= 4'd5);
    y_m     = (yng_cls >= 4'd2) && (yng_cls <= 4'd5);
    mem_iss = (o_iss && o_m) || (y_iss && y_m);
    st_iss  = (o_iss && (old_cls == 4'd3)) || (y_iss && (yng_cls == 4'd3));
    fst_iss = (o_iss && (old_cls == 4'd5)) || (y_iss && (yng_cls == 4'd5));
    br_iss  = (o_iss && (old_cls == 4'd8)) || (y_iss && (yng_cls == 4'd8));
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_count != 2'd3);

  // R1
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !old_valid |-> issue_count == 2'd0);

  // R2
  pipe_a_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_iss |-> !(o_a && y_a));

  // R3
  pipe_b_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_iss |-> !(o_b && y_b));

  // R4
  fp_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_iss |-> !(o_f && y_f));

  // R5
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_iss |=> !mem_iss);

  // R5
  fst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fst_iss |=> !mem_iss ##1 !mem_iss);

  // R6
  br_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_iss |=> issue_count == 2'd0);

  // R7
  solo_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_iss |-> (old_cls < 4'd12) && (yng_cls < 4'd12));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    old_valid && ((imd_busy && old_cls == 4'd7) || (fmul_busy && old_cls == 4'd10) ||
                  (fdsq_busy && old_cls == 4'd11)) |-> issue_count == 2'd0);

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (old_valid && issue_count == 2'd0) |-> stall);

endmodule

bind pair_issue_gate pair_issue_gate_chk u_chk (.*);

// File: tb/pair_issue_gate_bench.sv
`timescale 1ns/1ps
module pair_issue_gate_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       old_valid, yng_valid;
  logic [3:0] old_cls, yng_cls;
  logic       imd_busy, fmul_busy, fdsq_busy;
  logic [1:0] issue_count;
  logic       stall;

  int checks   = 0;
  int failures = 0;
  int m_hold   = 0;
  int m_bub    = 0;

  always #2 clk = ~clk;

  pair_issue_gate u_pair_issue_gate (
    .clk(clk), .rst_n(rst_n),
    .old_valid(old_valid), .old_cls(old_cls),
    .yng_valid(yng_valid), .yng_cls(yng_cls),
    .imd_busy(imd_busy), .fmul_busy(fmul_busy), .fdsq_busy(fdsq_busy),
    .issue_count(issue_count), .stall(stall)
  );

  function automatic bit needs_a(int c);  return c >= 1 && c <= 6;  endfunction
  function automatic bit needs_b(int c);  return c == 7 || c == 8;  endfunction
  function automatic bit needs_fp(int c); return c >= 9 && c <= 11; endfunction
  function automatic bit is_mem(int c);   return c >= 2 && c <= 5;  endfunction

  function automatic bit can_go(int c, bit ib, bit fb, bit db);
    if (is_mem(c) && m_hold > 0) return 0;
    if (c == 7 && ib) return 0;
    if (c == 10 && fb) return 0;
    if (c == 11 && db) return 0;
    return 1;
  endfunction

  function automatic int model_count(bit ov, int oc, bit yv, int yc, bit ib, bit fb, bit db);
    if (m_bub != 0 || !ov) return 0;
    if (!can_go(oc, ib, fb, db)) return 0;
    if (!yv || oc >= 12 || yc >= 12) return 1;
    if (!can_go(yc, ib, fb, db)) return 1;
    if (needs_a(oc) && needs_a(yc)) return 1;
    if (needs_b(oc) && needs_b(yc)) return 1;
    if (needs_fp(oc) && needs_fp(yc)) return 1;
    return 2;
  endfunction

  task automatic compare(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit ov, int oc, bit yv, int yc, bit ib, bit fb, bit db, string tag);
    int exp;
    @(negedge clk);
    old_valid = ov; old_cls = 4'(oc);
    yng_valid = yv; yng_cls = 4'(yc);
    imd_busy = ib; fmul_busy = fb; fdsq_busy = db;
    #1;
    exp = model_count(ov, oc, yv, yc, ib, fb, db);
    compare({tag, " issue_count"}, int'(issue_count), exp);
    compare({"R9 stall/", tag}, int'(stall), (int'(ov) + int'(yv) > exp) ? 1 : 0);
    @(posedge clk);
    begin
      int nh;
      nh = (m_hold > 0) ? m_hold - 1 : 0;
      m_bub = 0;
      for (int s = 0; s < exp; s++) begin
        int c;
        c = (s == 0) ? oc : yc;
        if (c == 3) nh = 1;
        if (c == 5) nh = 2;
        if (c == 8) m_bub = 1;
      end
      m_hold = nh;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    old_valid = 0; yng_valid = 0; old_cls = 0; yng_cls = 0;
    imd_busy = 0; fmul_busy = 0; fdsq_busy = 0;
    m_hold = 0; m_bub = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    do_reset();
    // R10 reset state: nothing held, load pairs
    step(1, 2, 1, 0, 0, 0, 0, "R10 post-reset");
    // R2 pipe A sharing
    step(1, 1, 1, 1, 0, 0, 0, "R2 shift+shift");
    step(1, 1, 1, 2, 0, 0, 0, "R2 shift+load");
    step(1, 6, 1, 4, 0, 0, 0, "R2 fxfer+fload");
    // R3 pipe B and flexible add/sub
    step(1, 0, 1, 1, 0, 0, 0, "R3 ialu+shift");
    step(1, 0, 1, 0, 0, 0, 0, "R3 ialu+ialu");
    step(1, 7, 1, 8, 0, 0, 0, "R3 mul+branch");
    step(1, 0, 1, 7, 0, 0, 0, "R3 ialu+mul");
    // R4 FP front end
    step(1, 9, 1, 10, 0, 0, 0, "R4 fadd+fmul");
    step(1, 11, 1, 9, 0, 0, 0, "R4 fdsq+fadd");
    step(1, 4, 1, 9, 0, 0, 0, "R4 fload+fadd");
    // R5 store hold
    step(1, 3, 1, 0, 0, 0, 0, "R5 store");
    step(1, 2, 1, 0, 0, 0, 0, "R5 load after store");
    step(1, 2, 1, 0, 0, 0, 0, "R5 load released");
    step(1, 5, 0, 0, 0, 0, 0, "R5 fstore");
    step(1, 2, 0, 0, 0, 0, 0, "R5 fstore hold 1");
    step(1, 4, 0, 0, 0, 0, 0, "R5 fstore hold 2");
    step(1, 4, 1, 9, 0, 0, 0, "R5 fstore released");
    // R6 branch bubble
    step(1, 8, 1, 0, 0, 0, 0, "R6 branch");
    step(1, 0, 1, 0, 0, 0, 0, "R6 bubble");
    step(1, 0, 1, 8, 0, 0, 0, "R6 young branch");
    step(1, 0, 0, 0, 0, 0, 0, "R6 bubble young");
    // R7 single dispatch
    step(1, 12, 1, 0, 0, 0, 0, "R7 solo old");
    step(1, 0, 1, 15, 0, 0, 0, "R7 solo young");
    // R8 busy inputs
    step(1, 7, 1, 0, 1, 0, 0, "R8 imd busy");
    step(1, 0, 1, 10, 0, 1, 0, "R8 fmul busy");
    step(1, 11, 0, 0, 0, 0, 1, "R8 fdsq busy");
    // R1 in-order
    step(0, 0, 1, 0, 0, 0, 0, "R1 no older");
    step(1, 7, 1, 0, 1, 0, 0, "R1 older blocked");
    // R10 reset clears hold and bubble
    step(1, 5, 0, 0, 0, 0, 0, "R10 fstore pre-reset");
    do_reset();
    step(1, 2, 1, 0, 0, 0, 0, "R10 load after reset");
    step(1, 8, 0, 0, 0, 0, 0, "R10 branch pre-reset");
    do_reset();
    step(1, 2, 1, 0, 0, 0, 0, "R10 issue after reset");
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15),
           $urandom_range(0, 5) != 0, $urandom_range(0, 15),
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, "R1-mix");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule